// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Controller

This controller moves words between a synchronous memory and a serial data port. It does not use fixed registers for each transfer. Instead it reads its work from a linked list of four-word descriptors held in memory. A host writes a chain pointer. The controller then reads the descriptor that the pointer names and loads its start address, address step and word count. After that it answers word requests from the port. Each answered request either reads a memory word and hands it to the port (transmit), or writes the port's word into memory (receive).

A chain pointer names the highest-addressed word of its descriptor, so the descriptor is read from the top down. Reading descending addresses, one per cycle, returns the buffer start address, then the address step, then the word count, then the link to the next descriptor. When the count runs out, a non-zero link starts the next fetch. Two descriptors that link to each other form an endless ring that alternates between two buffers. A zero link, or a cleared chain-enable, ends the chain with a one-cycle completion pulse. Clearing the DMA enable stops the channel quietly at the next word boundary.

Top module: `chain_dma`

## Requirements
- R1: While reset is held and after it is released, `mem_req`, `port_ack` and `done` are low until a chain is started.
- R2: A write on `cp_wr` starts a chain only when both `dma_en` and `chain_en` are high. Only bits 18:0 of `cp_wdata` form the pointer. A write with either enable low causes no memory activity.
- R3: A descriptor whose pointer is P is read on four consecutive cycles at addresses P, P-1, P-2, P-3. These hold, in that order, the buffer start index, the address modifier, the word count (bits 15:0) and the next-descriptor link (bits 18:0).
- R4: In transmit mode (`xmit`=1), each acknowledged word is the memory word at the current index. After each word the index advances by the modifier, modulo 2^19.
- R5: In receive mode (`xmit`=0), each accepted word from `port_rxdata` is written to memory at the current index, and the index advances as in R4.
- R6: `port_ack` is a one-cycle pulse, given in the cycle after a request is taken. It is given only while `port_req` was high in the cycle before.
- R7: When a descriptor's count is used up and chaining is enabled, a non-zero link starts a new fetch from that link. Two descriptors that link to each other run without end.
- R8: A zero link at the end of a descriptor returns the channel to idle and raises `done` for exactly one cycle.
- R9: Requests raised while a descriptor is being fetched wait until the fetch completes. Every word of every descriptor is transferred exactly once.
- R10: Clearing `dma_en` stops the channel at the next word boundary, with no further memory or port activity and no `done` pulse.
- R11: A descriptor with a count of zero moves no words, and its link is followed at once.
- R12: If `chain_en` is low when a descriptor's count runs out, the chain ends as for a zero link, with a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Channel enable |
| chain_en | input | 1 | Descriptor chaining enable |
| xmit | input | 1 | 1: memory to port, 0: port to memory |
| cp_wr | input | 1 | Host write strobe for the chain pointer |
| cp_wdata | input | DW | Chain pointer value; bits 18:0 used |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (when `mem_req`) |
| mem_addr | output | 19 | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |
| port_req | input | 1 | Port word request, held until acknowledged |
| port_ack | output | 1 | Word acknowledge pulse |
| port_rxdata | input | DW | Word from the port (receive) |
| port_txdata | output | DW | Word to the port, valid with `port_ack` (transmit) |
| done | output | 1 | One-cycle end-of-chain pulse |

## Verification
The bench walks each descriptor list on its own and compares every memory read address, write address and data word, and every transmitted word, in order. A wrong fetch order or a lost or doubled word therefore shows up at the first event that differs. One chain has a request pending while a fetch is in progress, which catches a design that drops or repeats a word at a descriptor boundary. The same chain passes through a zero-count descriptor, which catches a count that underflows into a long transfer. A pointer with high bits set catches missing masking. A two-descriptor ring is stopped by clearing the enable; a design that ignored the word boundary or pulsed `done` there would keep accessing memory or report completion. A chain whose chaining enable is dropped during its first descriptor must end after that descriptor alone.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int PTR_W   = 19;
  localparam int PHASE_W = 3;
  localparam logic [PHASE_W-1:0] PH_LINK = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_WORD} dma_state_e;
  typedef enum logic [1:0] {F_INDEX, F_MODIF, F_COUNT, F_LINK} desc_field_e;

  // address of the descriptor word read in a given fetch phase (top-down)
  function automatic logic [PTR_W-1:0] fetch_addr(input logic [PTR_W-1:0] tail,
                                                  input logic [PHASE_W-1:0] ph);
    return tail - PTR_W'(ph);
  endfunction

  // buffer index after one word
  function automatic logic [PTR_W-1:0] next_index(input logic [PTR_W-1:0] idx,
                                                  input logic [PTR_W-1:0] mdf);
    return idx + mdf;
  endfunction
endpackage

// File: rtl/chain_dma_desc.sv
module chain_dma_desc
  import chain_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  desc_field_e      cap_field,
  input  logic [DW-1:0]    cap_data,
  input  logic             step,
  output logic [PTR_W-1:0] index,
  output logic [PTR_W-1:0] modif,
  output logic [PTR_W-1:0] link,
  output logic [CW-1:0]    count,
  output logic             count_zero,
  output logic             count_last
);
  logic unused_hi;
  assign unused_hi = ^cap_data[DW-1:PTR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index <= '0;
      modif <= '0;
      link  <= '0;
      count <= '0;
    end else if (cap_en) begin
      case (cap_field)
        F_INDEX: index <= cap_data[PTR_W-1:0];
        F_MODIF: modif <= cap_data[PTR_W-1:0];
        F_COUNT: count <= cap_data[CW-1:0];
        default: link  <= cap_data[PTR_W-1:0];
      endcase
    end else if (step) begin
      index <= next_index(index, modif);
      count <= count - 1'b1;
    end
  end

  assign count_zero = (count == '0);
  assign count_last = (count == CW'(1));

  // R4: every word consumes exactly one count and one modifier step
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == CW'($past(count) - 1'b1));
  a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> index == PTR_W'($past(index) + $past(modif)));
endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
  import chain_dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_en,
  input  logic               chain_en,
  input  logic               cp_wr,
  input  logic [PTR_W-1:0]   cp_ptr,
  input  logic               port_req,
  input  logic [PTR_W-1:0]   link_rd,
  input  logic [PTR_W-1:0]   link,
  input  logic               count_zero,
  input  logic               count_last,
  output dma_state_e         state,
  output logic [PHASE_W-1:0] phase,
  output logic [PTR_W-1:0]   tail,
  output logic               done
);
  logic start, at_link, word_end, link_ok_fetch, link_ok_word;

  assign start         = (state == S_IDLE) && cp_wr && dma_en && chain_en;
  assign at_link       = (state == S_FETCH) && (phase == PH_LINK);
  assign word_end      = (state == S_WORD) && count_last;
  assign link_ok_fetch = chain_en && (link_rd != '0);
  assign link_ok_word  = chain_en && (link != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      phase <= '0;
      tail  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          tail  <= cp_ptr;
          phase <= '0;
          state <= S_FETCH;
        end
        S_FETCH: if (!at_link) begin
          phase <= phase + 1'b1;
        end else if (!count_zero) begin
          state <= S_XFER;
        end else if (link_ok_fetch) begin
          tail  <= link_rd;
          phase <= '0;
        end else begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        S_XFER: if (!dma_en) state <= S_IDLE;
                else if (port_req) state <= S_WORD;
        default: if (!word_end) begin
          state <= S_XFER;
        end else if (link_ok_word) begin
          tail  <= link;
          phase <= '0;
          state <= S_FETCH;
        end else begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_en,
  input  logic             chain_en,
  input  logic             xmit,
  input  logic             cp_wr,
  input  logic [DW-1:0]    cp_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             port_req,
  output logic             port_ack,
  input  logic [DW-1:0]    port_rxdata,
  output logic [DW-1:0]    port_txdata,
  output logic             done
);
  dma_state_e         state;
  logic [PHASE_W-1:0] phase;
  logic [PTR_W-1:0]   tail, index, modif, link;
  logic [CW-1:0]      count;
  logic               count_zero, count_last;
  logic               fetching, fetch_rd, word_take, cap_en, step;
  desc_field_e        cap_field;
  logic               unused_cp;

  assign unused_cp = ^cp_wdata[DW-1:PTR_W];

  chain_dma_seq i_seq (
    .clk, .rst_n, .dma_en, .chain_en, .cp_wr,
    .cp_ptr     (cp_wdata[PTR_W-1:0]),
    .port_req,
    .link_rd    (mem_rdata[PTR_W-1:0]),
    .link, .count_zero, .count_last,
    .state, .phase, .tail, .done
  );

  chain_dma_desc #(.DW(DW), .CW(CW)) i_desc (
    .clk, .rst_n, .cap_en, .cap_field,
    .cap_data (mem_rdata),
    .step, .index, .modif, .link, .count, .count_zero, .count_last
  );

  // named events
  assign fetching  = (state == S_FETCH);
  assign fetch_rd  = fetching && (phase != PH_LINK);
  assign word_take = (state == S_XFER) && dma_en && port_req;
  assign cap_en    = fetching && (phase != '0);
  assign cap_field = desc_field_e'(2'(phase - 1'b1));
  assign step      = (state == S_WORD);

  assign mem_req     = fetch_rd || word_take;
  assign mem_we      = word_take && !xmit;
  assign mem_addr    = fetching ? fetch_addr(tail, phase) : index;
  assign mem_wdata   = port_rxdata;
  assign port_ack    = step;
  assign port_txdata = mem_rdata;

  // R6: acknowledge is one cycle and follows a held request
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    port_ack |=> !port_ack);
  a_r6_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    port_ack |-> $past(port_req));
  // R3: descriptor words are read on descending addresses, back to back
  a_r3_fetch_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_rd && phase != '0) |-> mem_addr == PTR_W'($past(mem_addr) - 1'b1));
  // R8: completion cycle carries no memory or port activity
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_req && !port_ack));
endmodule

// File: tb/test_chain_dma.sv
module test_chain_dma;
  localparam int DW = 32;
  localparam int unsigned MASK = 32'h0007_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_en = 1'b0, chain_en = 1'b0, xmit = 1'b1, cp_wr = 1'b0;
  logic [DW-1:0] cp_wdata = '0;
  logic mem_req, mem_we, port_ack, done;
  logic [18:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0, port_txdata, port_rxdata;
  logic port_req = 1'b0;
  logic want = 1'b0;
  int unsigned rx_n = 0;

  always #10 clk = ~clk;

  chain_dma #(.DW(DW), .CW(16)) i_chain_dma (
    .clk, .rst_n, .dma_en, .chain_en, .xmit, .cp_wr, .cp_wdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .port_req, .port_ack, .port_rxdata, .port_txdata, .done
  );

  bit [31:0] mem [int unsigned];
  function automatic bit [31:0] rdm(input int unsigned a);
    return mem.exists(a & MASK) ? mem[a & MASK] : 32'h0;
  endfunction

  // memory and port responders
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= rdm(int'(mem_addr));
    port_req <= want && !port_ack;
    if (port_ack) rx_n <= rx_n + 1;
  end
  assign port_rxdata = 32'hA000_0000 + rx_n;

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected event queues
  int unsigned exp_rd[$], exp_wa[$], exp_wd[$], exp_tx[$];
  string exp_tag[$];
  int done_cnt = 0, ack_cnt = 0, req_seen = 0, rd_seen = 0;
  bit prev_req = 0, first_pending = 0;
  int unsigned first_rd = 0;

  task automatic expect_chain(input int unsigned cp, input bit tx, input bit follow,
                              input int maxw, input int unsigned rx0);
    int unsigned p, rxv;
    int words;
    string ft;
    p = cp & MASK; rxv = rx0; words = 0; ft = "R3";
    for (int d = 0; d < 64; d++) begin
      int unsigned idx, md, cnt, nx;
      idx = rdm(p) & MASK;
      md  = rdm(p - 1) & MASK;
      cnt = rdm(p - 2) & 32'hFFFF;
      nx  = rdm(p - 3) & MASK;
      if (cnt == 0 && d > 0) ft = "R11";
      for (int k = 0; k < 4; k++) begin
        exp_rd.push_back((p - k) & MASK);
        exp_tag.push_back(ft);
      end
      for (int i = 0; i < int'(cnt); i++) begin
        if (words >= maxw) return;
        if (tx) begin
          exp_rd.push_back(idx); exp_tag.push_back("R4"); exp_tx.push_back(rdm(idx));
        end else begin
          exp_wa.push_back(idx); exp_wd.push_back(rxv); rxv++;
        end
        words++;
        idx = (idx + md) & MASK;
      end
      if (!follow || nx == 0) return;
      p = nx; ft = "R7";
    end
  endtask

  // per-cycle monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) req_seen++;
      if (mem_req && !mem_we) begin
        rd_seen++;
        if (first_pending) begin first_rd = mem_addr; first_pending = 0; end
        if (exp_rd.size() == 0) check(0, "R7", "unexpected read", mem_addr, 0);
        else begin
          int unsigned e; string t;
          e = exp_rd.pop_front(); t = exp_tag.pop_front();
          check(int'(mem_addr) == e, t, "read address", mem_addr, e);
        end
      end
      if (mem_req && mem_we) begin
        if (exp_wa.size() == 0) check(0, "R5", "unexpected write", mem_addr, 0);
        else begin
          int unsigned ea, ed;
          ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
          check(int'(mem_addr) == ea, "R5", "write address", mem_addr, ea);
          check(mem_wdata == ed, "R5", "write data", mem_wdata, ed);
        end
      end
      if (port_ack) begin
        ack_cnt++;
        check(prev_req, "R6", "ack without prior request", 0, 1);
        if (xmit) begin
          if (exp_tx.size() == 0) check(0, "R4", "unexpected tx word", port_txdata, 0);
          else begin
            int unsigned ew;
            ew = exp_tx.pop_front();
            check(port_txdata == ew, "R4", "tx word", port_txdata, ew);
          end
        end
      end
      if (done) done_cnt++;
      prev_req = port_req;
    end
  end

  task automatic tick(); @(posedge clk); #5; endtask
  task automatic host_write(input logic [31:0] v);
    cp_wr = 1'b1; cp_wdata = v; tick(); cp_wr = 1'b0;
  endtask
  task automatic wait_done(input int lim);
    int d0;
    d0 = done_cnt;
    for (int i = 0; i < lim && done_cnt == d0; i++) tick();
    repeat (3) tick();
  endtask
  task automatic put_desc(input int unsigned base, input int unsigned nx,
                          input int unsigned cnt, input int unsigned md, input int unsigned idx);
    mem[base] = nx; mem[base + 1] = cnt; mem[base + 2] = md; mem[base + 3] = idx;
  endtask

  initial begin
    int snap;
    // memory image
    put_desc(32'h100, 32'h113, 3, 1, 32'h400);
    put_desc(32'h110, 32'h123, 0, 5, 32'h777);
    put_desc(32'h120, 32'h000, 2, 3, 32'h500);
    put_desc(32'h200, 32'h123, 2, 2, 32'h600);
    put_desc(32'h300, 32'h313, 4, 1, 32'h800);
    put_desc(32'h310, 32'h303, 4, 2, 32'h900);
    for (int i = 0; i < 8; i++) begin
      mem[32'h400 + i] = 32'h1111_0000 + i;
      mem[32'h500 + i] = 32'h2222_0000 + i;
      mem[32'h600 + i] = 32'h3333_0000 + i;
    end

    // R1 reset state
    repeat (3) tick();
    check(!mem_req && !port_ack && !done, "R1", "outputs in reset", {mem_req, port_ack, done}, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    check(!mem_req && !port_ack && !done, "R1", "outputs after reset", {mem_req, port_ack, done}, 0);

    // R2 writes ignored with an enable low
    dma_en = 1'b1; chain_en = 1'b0;
    host_write(32'h103); repeat (10) tick();
    dma_en = 1'b0; chain_en = 1'b1;
    host_write(32'h103); repeat (10) tick();
    check(req_seen == 0, "R2", "memory activity with enable low", req_seen, 0);

    // transmit chain: A -> zero-count Z -> B -> end; request pending during fetch
    dma_en = 1'b1; chain_en = 1'b1; xmit = 1'b1; want = 1'b1;
    expect_chain(32'h103, 1, 1, 1000, 0);
    first_pending = 1;
    host_write(32'hFFF8_0103);
    wait_done(500);
    check(first_rd == 32'h103, "R2", "masked pointer first read", first_rd, 32'h103);
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(exp_rd.size() == 0 && exp_tx.size() == 0, "R7", "chain fully walked", exp_rd.size(), 0);
    check(ack_cnt == 5, "R9", "words transferred", ack_cnt, 5);

    // chaining disabled during first descriptor
    done_cnt = 0; ack_cnt = 0;
    expect_chain(32'h203, 1, 0, 1000, 0);
    host_write(32'h203);
    chain_en = 1'b0;
    wait_done(500);
    check(done_cnt == 1, "R12", "done pulses", done_cnt, 1);
    check(ack_cnt == 2, "R12", "words transferred", ack_cnt, 2);
    check(exp_rd.size() == 0, "R12", "reads left over", exp_rd.size(), 0);

    // receive ring, stopped by clearing the enable
    chain_en = 1'b1; xmit = 1'b0; done_cnt = 0; ack_cnt = 0;
    expect_chain(32'h303, 0, 1, 40, 32'hA000_0000 + rx_n);
    host_write(32'h303);
    for (int i = 0; i < 500 && ack_cnt < 10; i++) tick();
    dma_en = 1'b0;
    repeat (6) tick();
    snap = req_seen;
    repeat (30) tick();
    check(req_seen == snap, "R10", "activity after stop", req_seen - snap, 0);
    check(ack_cnt >= 10 && ack_cnt <= 11, "R10", "words at stop", ack_cnt, 10);
    check(done_cnt == 0, "R10", "done on stop", done_cnt, 0);
    check(mem[32'h902] != 32'h0, "R7", "ring reached second buffer", mem[32'h902], 1);
    want = 1'b0;
    exp_rd.delete(); exp_tag.delete(); exp_wa.delete(); exp_wd.delete(); exp_tx.delete();
    repeat (3) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule